// File: doc/BRIEF.md
# Power-State Transition Interrupt Detector

This block keeps a two-bit device power state that an external bus agent writes, and turns certain changes of that state into interrupt events. The four states are D0 (normal), D1 (bus idle), D2 (clock stop) and D3 (power down). Each state has its own sticky status bit and its own mask bit. A single interrupt line combines the status bits that are set and unmasked.

Only specific source-to-target moves count as events. A move into D0 counts from any low-power state. A move into D1, D2 or D3 counts only when it comes from a lower-numbered state. Any other write changes the state and raises nothing. Reset puts the state in D0 and raises no event.

Local software reads the status bits and clears them by writing ones. It also reads and writes the mask. A separate quiesce output tells local logic to stop issuing accesses once the power-down event is seen. The bus clock can stop as soon as 16 clocks after a D3 request, so any access still in flight at that point could hang.

Top module: `pm_state_irq_top`

## Requirements
- R1: During and after reset the state reads D0 (code 0), all status bits are 0, all mask bits are 1, and irq_o and quiesce_o are 0. No D0 event is raised by reset, including a reset taken while in D3.
- R2: A state write (st_wr_en high at a clock edge) makes state_o equal the written value after that edge. State codes: D0=0, D1=1, D2=2, D3=3.
- R3: Status bit 0 (D0) is set by a write of D0 when the current state is D1, D2 or D3.
- R4: Status bit 1 (D1) is set only by a write of D1 when the current state is D0.
- R5: Status bit 2 (D2) is set by a write of D2 when the current state is D0 or D1.
- R6: Status bit 3 (D3) is set by a write of D3 when the current state is D0, D1 or D2.
- R7: Any other write updates the state but sets no status bit. This includes D2 to D1, D3 to D2, D3 to D1 and a write of the current value.
- R8: Status bits are sticky. A clear strobe (sts_clr_en) clears exactly the status bits whose sts_clr_bits bit is 1 and leaves the others unchanged.
- R9: When an event and a clear of the same status bit fall in the same cycle, the bit is set after that edge.
- R10: The mask (bit k masks state Dk, 1 = masked) is written by msk_wr_en and read on msk_o. irq_o is high exactly when some status bit is set and its mask bit is 0.
- R11: quiesce_o is high whenever the D3 status bit is set or the current state is D3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| st_wr_en | input | 1 | Bus agent writes the power-state field |
| st_wr_data | input | 2 | Power-state value being written |
| state_o | output | 2 | Current power state |
| sts_clr_en | input | 1 | Software write-one-to-clear strobe for status |
| sts_clr_bits | input | 4 | Status bits to clear |
| msk_wr_en | input | 1 | Software mask write strobe |
| msk_wr_data | input | 4 | New mask value |
| sts_o | output | 4 | Sticky status, bit k = event into Dk |
| msk_o | output | 4 | Mask register |
| irq_o | output | 1 | Combined interrupt |
| quiesce_o | output | 1 | Stop issuing local accesses |

## Verification
The table walks all sixteen from/to pairs of the state field. This separates the qualifying moves for each target from the ones that must stay silent. It shows that D1 is reached only from D0, while D2 and D3 also accept shallower low-power sources, and that a write of the current value never counts. With the mask open, each pair also checks that irq_o follows exactly the expected flag. Directed patterns cover the remaining cases: partial write-one-to-clear, a clear and an event on the same bit in the same cycle, mask-only suppression of the interrupt, quiesce while in D3 after its flag is cleared, and a reset taken from D3.

// File: rtl/pm_irq_pkg.sv
package pm_irq_pkg;
  localparam int PM_NUM_ST = 4;
  localparam int PM_ST_W   = $clog2(PM_NUM_ST);

  typedef enum logic [PM_ST_W-1:0] {
    PS_D0 = 2'd0,
    PS_D1 = 2'd1,
    PS_D2 = 2'd2,
    PS_D3 = 2'd3
  } pstate_e;
endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/pm_state_track.sv
module pm_state_track
  import pm_irq_pkg::*;
#(
  parameter int NS = PM_NUM_ST,
  parameter int SW = PM_ST_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_data,
  output logic [SW-1:0] state_o,
  output logic [NS-1:0] event_o
);
  logic [SW-1:0] state_q, state_d;

  // next-state process
  always_comb begin
    state_d = state_q;
    if (wr_en) state_d = wr_data;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state_q <= SW'(PS_D0);
    else if (wr_en) state_q <= state_d;
  end

  // Transition qualification: entering D0 counts from any other state;
  // entering Dk (k>0) counts only from a lower-numbered state.
  for (genvar k = 0; k < NS; k++) begin : g_qual
    if (k == 0) begin : g_wake
      assign event_o[k] = wr_en && (wr_data == SW'(k)) && (state_q != SW'(k));
    end else begin : g_deeper
      assign event_o[k] = wr_en && (wr_data == SW'(k)) && (state_q < SW'(k));
    end
  end

  assign state_o = state_q;

  // at most one target state per write
  assert_single_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(event_o));
endmodule

// File: rtl/pm_irq_status.sv
module pm_irq_status #(
  parameter int NS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] event_i,
  input  logic          clr_en,
  input  logic [NS-1:0] clr_bits,
  input  logic          msk_we,
  input  logic [NS-1:0] msk_wd,
  output logic [NS-1:0] sts_o,
  output logic [NS-1:0] msk_o,
  output logic          irq_o
);
  logic [NS-1:0] sts_q, sts_d, msk_q, msk_d, clr_mask;
  logic          sts_en;

  assign clr_mask = clr_en ? clr_bits : '0;
  assign sts_en   = clr_en || (|event_i);

  // next-state process: event has priority over clear
  always_comb begin
    sts_d = (sts_q & ~clr_mask) | event_i;
    msk_d = msk_we ? msk_wd : msk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      msk_q <= '1;
    end else begin
      if (sts_en) sts_q <= sts_d;
      if (msk_we) msk_q <= msk_d;
    end
  end

  assign irq_o = |(sts_q & ~msk_q);
  assign sts_o = sts_q;
  assign msk_o = msk_q;

  assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|event_i) |=> ((sts_q & $past(event_i)) == $past(event_i)));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & $past(sts_q & ~clr_mask)) == $past(sts_q & ~clr_mask)));

  assert_all_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (&msk_q) |-> !irq_o);
endmodule

// File: rtl/pm_state_irq_top.sv
module pm_state_irq_top
  import pm_irq_pkg::*;
#(
  parameter int NS = PM_NUM_ST,
  parameter int SW = PM_ST_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_wr_en,
  input  logic [SW-1:0] st_wr_data,
  output logic [SW-1:0] state_o,
  input  logic          sts_clr_en,
  input  logic [NS-1:0] sts_clr_bits,
  input  logic          msk_wr_en,
  input  logic [NS-1:0] msk_wr_data,
  output logic [NS-1:0] sts_o,
  output logic [NS-1:0] msk_o,
  output logic          irq_o,
  output logic          quiesce_o
);
  localparam int DEEP = NS - 1;

  logic          rst_q_n;
  logic [NS-1:0] ev;

  pm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_q_n));

  pm_state_track #(.NS(NS), .SW(SW)) u_track (
    .clk(clk), .rst_n(rst_q_n), .wr_en(st_wr_en), .wr_data(st_wr_data),
    .state_o(state_o), .event_o(ev));

  pm_irq_status #(.NS(NS)) u_sts (
    .clk(clk), .rst_n(rst_q_n), .event_i(ev),
    .clr_en(sts_clr_en), .clr_bits(sts_clr_bits),
    .msk_we(msk_wr_en), .msk_wd(msk_wr_data),
    .sts_o(sts_o), .msk_o(msk_o), .irq_o(irq_o));

  assign quiesce_o = sts_o[DEEP] || (state_o == SW'(DEEP));

  assert_state_follows_write_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    st_wr_en |=> (state_o == $past(st_wr_data)));

  assert_wake_source_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(sts_o[0]) |-> ($past(state_o) != SW'(PS_D0)) && (state_o == SW'(PS_D0)));

  assert_d1_from_d0_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(sts_o[1]) |-> ($past(state_o) == SW'(PS_D0)));

  assert_quiesce_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
    sts_o[DEEP] |-> quiesce_o);
endmodule

// File: tb/pm_state_irq_top_tb.sv
module pm_state_irq_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       st_wr_en = 1'b0;
  logic [1:0] st_wr_data = '0;
  logic [1:0] state_o;
  logic       sts_clr_en = 1'b0;
  logic [3:0] sts_clr_bits = '0;
  logic       msk_wr_en = 1'b0;
  logic [3:0] msk_wr_data = '0;
  logic [3:0] sts_o, msk_o;
  logic       irq_o, quiesce_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk; // 125 MHz

  pm_state_irq_top u_dut (
    .clk(clk), .rst_n(rst_n), .st_wr_en(st_wr_en), .st_wr_data(st_wr_data),
    .state_o(state_o), .sts_clr_en(sts_clr_en), .sts_clr_bits(sts_clr_bits),
    .msk_wr_en(msk_wr_en), .msk_wr_data(msk_wr_data), .sts_o(sts_o),
    .msk_o(msk_o), .irq_o(irq_o), .quiesce_o(quiesce_o));

  // {from, to, expected status}
  localparam logic [7:0] VEC [16] = '{
    {2'd0, 2'd0, 4'b0000}, {2'd0, 2'd1, 4'b0010}, {2'd0, 2'd2, 4'b0100}, {2'd0, 2'd3, 4'b1000},
    {2'd1, 2'd0, 4'b0001}, {2'd1, 2'd1, 4'b0000}, {2'd1, 2'd2, 4'b0100}, {2'd1, 2'd3, 4'b1000},
    {2'd2, 2'd0, 4'b0001}, {2'd2, 2'd1, 4'b0000}, {2'd2, 2'd2, 4'b0000}, {2'd2, 2'd3, 4'b1000},
    {2'd3, 2'd0, 4'b0001}, {2'd3, 2'd1, 4'b0000}, {2'd3, 2'd2, 4'b0000}, {2'd3, 2'd3, 4'b0000}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_state(input logic [1:0] v);
    @(negedge clk); st_wr_en = 1'b1; st_wr_data = v;
    @(negedge clk); st_wr_en = 1'b0;
  endtask

  task automatic clr(input logic [3:0] b);
    @(negedge clk); sts_clr_en = 1'b1; sts_clr_bits = b;
    @(negedge clk); sts_clr_en = 1'b0; sts_clr_bits = '0;
  endtask

  task automatic wr_mask(input logic [3:0] m);
    @(negedge clk); msk_wr_en = 1'b1; msk_wr_data = m;
    @(negedge clk); msk_wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 state in reset", 8'(state_o), 8'h0);
    chk("R1 sts in reset", 8'(sts_o), 8'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        do_reset();
        chk("R1 state", 8'(state_o), 8'h0);
        chk("R1 sts (no D0 flag)", 8'(sts_o), 8'h0);
        chk("R1 mask", 8'(msk_o), 8'hF);
        chk("R1 irq/quiesce", {6'd0, irq_o, quiesce_o}, 8'h0);

        wr_mask(4'h0);
        chk("R10 mask readback", 8'(msk_o), 8'h0);

        for (int i = 0; i < 16; i++) begin
          logic [1:0] f, t;
          logic [3:0] e;
          string tag;
          {f, t, e} = VEC[i];
          wr_state(f);
          clr(4'hF);
          wr_state(t);
          case (t)
            2'd0: tag = "R3";
            2'd1: tag = "R4";
            2'd2: tag = "R5";
            default: tag = "R6";
          endcase
          if (e == 4'b0) tag = "R7";
          chk($sformatf("%s sts %0d->%0d", tag, f, t), 8'(sts_o), 8'(e));
          chk($sformatf("R2 state %0d->%0d", f, t), 8'(state_o), 8'(t));
          chk($sformatf("R10 irq %0d->%0d", f, t), 8'(irq_o), 8'(|e));
        end

        // R8: sticky and partial clear
        wr_state(2'd0); clr(4'hF);
        wr_state(2'd1); wr_state(2'd2); wr_state(2'd3); wr_state(2'd0);
        chk("R8 accumulate", 8'(sts_o), 8'hF);
        clr(4'b0101);
        chk("R8 partial clear", 8'(sts_o), 8'b1010);
        repeat (3) @(negedge clk);
        chk("R8 sticky hold", 8'(sts_o), 8'b1010);

        // R9: clear and event on D3 bit in the same cycle
        clr(4'hF);
        @(negedge clk);
        st_wr_en = 1'b1; st_wr_data = 2'd3; sts_clr_en = 1'b1; sts_clr_bits = 4'hF;
        @(negedge clk);
        st_wr_en = 1'b0; sts_clr_en = 1'b0; sts_clr_bits = '0;
        chk("R9 event beats clear", 8'(sts_o), 8'b1000);

        // R11: quiesce from flag and from state
        chk("R11 quiesce flag", 8'(quiesce_o), 8'h1);
        clr(4'b1000);
        chk("R11 quiesce in D3", 8'(quiesce_o), 8'h1);
        wr_state(2'd0);
        clr(4'hF);
        chk("R11 quiesce released", 8'(quiesce_o), 8'h0);

        // R10: masking only suppresses irq
        wr_mask(4'b0111);
        wr_state(2'd2);
        chk("R10 masked D2 irq", 8'(irq_o), 8'h0);
        chk("R10 masked D2 sts", 8'(sts_o), 8'b0100);
        wr_mask(4'b0011);
        chk("R10 unmasked D2 irq", 8'(irq_o), 8'h1);
        wr_mask(4'hF);
        chk("R10 all masked", 8'(irq_o), 8'h0);

        // R1: reset from D3 gives D0 and no D0 flag
        wr_state(2'd3);
        do_reset();
        chk("R1 state after D3 reset", 8'(state_o), 8'h0);
        chk("R1 no D0 flag after reset", 8'(sts_o), 8'h0);
        chk("R1 mask after reset", 8'(msk_o), 8'hF);
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule